// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table

This block holds the per-vector interrupt state of a device function that signals interrupts by memory writes. One register page contains a table of vector entries in its lower half and a bit array of waiting requests in its upper half. Each entry has a 64-bit message address, a 32-bit message data word and a control word whose lowest bit masks the vector. Software reaches the page through a plain 32-bit register port. Only the offset within the page is decoded, so the page base and any higher address bits play no part.

Device logic raises requests on one line per vector. A request always sets the waiting bit of its vector. A vector whose bit is set, whose mask is clear and whose function-level enable input is high is delivered. Delivery loads the entry's address and data onto a valid/ready message port and clears the waiting bit. Clearing a mask, or raising the enable, therefore sends a held request without any further request. When several vectors qualify in the same cycle, the lowest index goes first, one message per handshake.

Top module: `irqvec_table`

## Requirements
- R1: After reset every table word reads 0, except the control word of each vector, which reads 1 (masked). All waiting bits read 0 and `msg_valid` is low.
- R2: Accesses decode only `reg_addr & (PAGE_BYTES-1)`, so two addresses with the same page offset reach the same register.
- R3: The entry for vector v starts at offset 16*v. Word 0 at +0 is address bits 31:0, word 1 at +4 is address bits 63:32, word 2 at +8 is data, and word 3 at +12 is control. Only bit 0 of the control word is stored, and its other bits read 0.
- R4: The waiting-bit array starts at offset PAGE_BYTES/2. The bit for vector v is bit v%8 of byte v/8, so it is bit v of the 32-bit word read at PAGE_BYTES/2.
- R5: A request on a masked vector, or any request while `msix_en` is low, sets the waiting bit and produces no message.
- R6: A request on an unmasked vector with `msix_en` high makes `msg_valid` high after the second rising edge that follows the request being driven, and clears the waiting bit.
- R7: A table write that clears the mask of a vector whose waiting bit is set delivers that vector's message and clears the bit.
- R8: The message carries address {word 1, word 0} and data word 2. While `msg_valid` is high and `msg_ready` is low, valid, address and data hold.
- R9: Writes to the waiting-bit region are ignored. Reads of offsets that hold neither an implemented entry nor the first waiting-bit word return 0.
- R10: When several vectors qualify together, they are sent one per handshake in ascending index order.
- R11: Raising `msix_en` delivers the waiting, unmasked vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msix_en | input | 1 | Function-level enable for message delivery |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address (only page offset decoded) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq_req | input | NUM_VEC | Per-vector interrupt request, one cycle per request |
| msg_valid | output | 1 | Message write pending on the port |
| msg_ready | input | 1 | Receiver accepts the message at the rising edge |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest state to reach from the ports is several vectors qualifying at the same moment while the message port is stalled. This is the only case in which ordering and holding stable both matter. The bench unmasks three vectors and drops `msg_ready`. It then raises all three requests in one cycle and checks that the first message holds still for several cycles. When it releases ready, the scoreboard expects the three messages in ascending order. Held delivery is reached by requesting on a masked vector, or with the enable low, and then clearing the mask or raising the enable.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  localparam int unsigned ENTRY_BYTES = 16;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned MAX_VEC     = 32;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;

  // vector index held at a page offset
  function automatic logic [31:0] entry_of(input logic [31:0] off);
    return off / ENTRY_BYTES;
  endfunction

  // word slot within an entry
  function automatic logic [1:0] word_of(input logic [31:0] off);
    return 2'((off % ENTRY_BYTES) / WORD_BYTES);
  endfunction

  // lowest set bit of a request vector
  function automatic logic [MAX_VEC-1:0] lowest_bit(input logic [MAX_VEC-1:0] x);
    return x & (~x + 1'b1);
  endfunction
endpackage

// File: rtl/irqvec_decode.sv
module irqvec_decode
  import irqvec_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned NUM_VEC    = 8,
  parameter int unsigned ADDR_W     = 32,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned VEC_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              tbl_hit,
  output logic              pend_hit,
  output logic [VEC_W-1:0]  vec_idx,
  output logic [1:0]        word_idx,
  output logic              wr_tbl,
  output logic              wr_pend
);
  localparam logic [31:0] TBL_END  = 32'(NUM_VEC * ENTRY_BYTES);
  localparam logic [31:0] PEND_LO  = 32'(PAGE_BYTES / 2);
  localparam logic [31:0] PEND_TOP = 32'(PAGE_BYTES);

  logic [31:0] off;
  logic        in_pend_half;

  always_comb begin
    off          = 32'(addr[OFF_W-1:0]);
    tbl_hit      = off < TBL_END;
    in_pend_half = (off >= PEND_LO) && (off < PEND_TOP);
    pend_hit     = (off >= PEND_LO) && (off < PEND_LO + WORD_BYTES);
    vec_idx      = VEC_W'(entry_of(off));
    word_idx     = word_of(off);
    wr_tbl       = wr && tbl_hit;
    wr_pend      = wr && in_pend_half;
  end
endmodule

// File: rtl/irqvec_store.sv
module irqvec_store #(
  parameter int unsigned NUM_VEC = 8,
  localparam int unsigned VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_tbl,
  input  logic [VEC_W-1:0]          vec_idx,
  input  logic [1:0]                word_idx,
  input  logic [31:0]               wdata,
  output logic [NUM_VEC-1:0][31:0]  addr_lo,
  output logic [NUM_VEC-1:0][31:0]  addr_hi,
  output logic [NUM_VEC-1:0][31:0]  data_w,
  output logic [NUM_VEC-1:0]        mask_vec
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_entry
    logic sel;
    assign sel = wr_tbl && (vec_idx == VEC_W'(v));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_lo[v]  <= '0;
        addr_hi[v]  <= '0;
        data_w[v]   <= '0;
        mask_vec[v] <= 1'b1;
      end else if (sel) begin
        case (word_idx)
          2'd0:    addr_lo[v]  <= wdata;
          2'd1:    addr_hi[v]  <= wdata;
          2'd2:    data_w[v]   <= wdata;
          default: mask_vec[v] <= wdata[0];
        endcase
      end
    end
  end
endmodule

// File: rtl/irqvec_pend.sv
module irqvec_pend
  import irqvec_pkg::*;
#(
  parameter int unsigned NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] mask_vec,
  input  logic               msix_en,
  input  logic               slot_free,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] grant,
  output logic               fire
);
  logic [NUM_VEC-1:0] ready_vec;
  logic [MAX_VEC-1:0] wide;

  always_comb begin
    ready_vec = pend & ~mask_vec & {NUM_VEC{msix_en}};
    wide      = lowest_bit(MAX_VEC'(ready_vec));
    grant     = wide[NUM_VEC-1:0];
    fire      = slot_free && (|ready_vec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~(fire ? grant : '0)) | irq_req;
  end
endmodule

// File: rtl/irqvec_msgout.sv
module irqvec_msgout
  import irqvec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  msg_t  load_msg,
  input  logic  ready,
  output logic  valid,
  output msg_t  msg,
  output logic  slot_free
);
  assign slot_free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      msg   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      msg   <= load_msg;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irqvec_table.sv
module irqvec_table
  import irqvec_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned NUM_VEC    = 8,
  parameter int unsigned ADDR_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msix_en,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] irq_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int unsigned VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic                     tbl_hit, pend_hit, wr_tbl, wr_pend;
  logic [VEC_W-1:0]         vec_idx;
  logic [1:0]               word_idx;
  logic [NUM_VEC-1:0][31:0] addr_lo, addr_hi, data_w;
  logic [NUM_VEC-1:0]       mask_vec, pend, grant;
  logic                     fire, slot_free;
  msg_t                     sel_msg, out_msg;

  irqvec_decode #(.PAGE_BYTES(PAGE_BYTES), .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .tbl_hit(tbl_hit), .pend_hit(pend_hit),
    .vec_idx(vec_idx), .word_idx(word_idx), .wr_tbl(wr_tbl), .wr_pend(wr_pend)
  );

  irqvec_store #(.NUM_VEC(NUM_VEC)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_tbl(wr_tbl), .vec_idx(vec_idx),
    .word_idx(word_idx), .wdata(reg_wdata), .addr_lo(addr_lo),
    .addr_hi(addr_hi), .data_w(data_w), .mask_vec(mask_vec)
  );

  irqvec_pend #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_vec(mask_vec),
    .msix_en(msix_en), .slot_free(slot_free), .pend(pend), .grant(grant),
    .fire(fire)
  );

  // message of the granted vector (grant is one-hot or zero)
  always_comb begin
    sel_msg = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (grant[v]) sel_msg = '{addr: {addr_hi[v], addr_lo[v]}, data: data_w[v]};
    end
  end

  irqvec_msgout u_out (
    .clk(clk), .rst_n(rst_n), .load(fire), .load_msg(sel_msg),
    .ready(msg_ready), .valid(msg_valid), .msg(out_msg), .slot_free(slot_free)
  );

  assign msg_addr = out_msg.addr;
  assign msg_data = out_msg.data;

  always_comb begin
    reg_rdata = '0;
    if (tbl_hit) begin
      case (word_idx)
        2'd0:    reg_rdata = addr_lo[vec_idx];
        2'd1:    reg_rdata = addr_hi[vec_idx];
        2'd2:    reg_rdata = data_w[vec_idx];
        default: reg_rdata = {31'b0, mask_vec[vec_idx]};
      endcase
    end else if (pend_hit) begin
      reg_rdata = 32'(pend);
    end
  end
endmodule

// File: rtl/irqvec_table_chk.sv
module irqvec_table_chk #(
  parameter int unsigned NUM_VEC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msix_en,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [NUM_VEC-1:0] irq_req,
  input logic [NUM_VEC-1:0] mask_vec,
  input logic [NUM_VEC-1:0] pend,
  input logic [NUM_VEC-1:0] grant,
  input logic               fire,
  input logic               wr_pend
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_no_masked_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (grant & (mask_vec | {NUM_VEC{!msix_en}})) == '0);

  p_clear_after_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ((irq_req & grant) == '0) |=> (pend & $past(grant)) == '0);

  p_pend_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend && (irq_req == '0) && !fire |=> pend == $past(pend));

  p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $countones(grant) == 1);

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind irqvec_table irqvec_table_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .msix_en(msix_en), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
  .irq_req(irq_req), .mask_vec(mask_vec), .pend(pend), .grant(grant),
  .fire(fire), .wr_pend(wr_pend)
);

// File: tb/tb_irqvec_table.sv
module tb_irqvec_table;
  localparam int unsigned PAGE = 4096;
  localparam int unsigned NV   = 8;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] PEND = BASE + PAGE / 2;

  logic clk = 1'b0, rst_n = 1'b0, msix_en = 1'b0, reg_wr = 1'b0, msg_ready = 1'b1;
  logic [31:0] reg_addr = BASE, reg_wdata = '0, reg_rdata;
  logic [NV-1:0] irq_req = '0;
  logic msg_valid;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0, fails = 0;
  logic [95:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  irqvec_table #(.PAGE_BYTES(PAGE), .NUM_VEC(NV), .ADDR_W(32)) dut (.*);

  function automatic logic [31:0] lo_of(int v); return 32'hFEE0_0000 + 32'(v) * 16; endfunction
  function automatic logic [31:0] hi_of(int v); return 32'(v) + 1; endfunction
  function automatic logic [31:0] dt_of(int v); return 32'hD000 + 32'(v); endfunction
  function automatic logic [31:0] ent(int v, int w); return BASE + 32'(v * 16 + w * 4); endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [31:0] a, logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic irq(logic [NV-1:0] bits);
    @(negedge clk); irq_req = bits;
    @(negedge clk); irq_req = '0;
  endtask

  task automatic expect_msg(int v, string req);
    exp_q.push_back({hi_of(v), lo_of(v), dt_of(v)});
    tag_q.push_back(req);
  endtask

  // monitor: handshake happens at the posedge after this sample
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 unexpected message actual=%h expected=none", {msg_addr, msg_data});
      end else begin
        logic [95:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({msg_addr, msg_data} !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, {msg_addr, msg_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", ent(0, 0), 0);
    rd("R1", ent(3, 2), 0);
    rd("R1", ent(0, 3), 1);
    rd("R1", ent(7, 3), 1);
    rd("R1", PEND, 0);
    chk("R1", 64'(msg_valid), 0);

    // program vectors 0..4; vector 2 through an aliased address (R2)
    for (int v = 0; v < 5; v++) begin
      logic [31:0] alias_off;
      alias_off = (v == 2) ? 32'(3 * PAGE) : 32'd0;
      wr(ent(v, 0) + alias_off, lo_of(v));
      wr(ent(v, 1) + alias_off, hi_of(v));
      wr(ent(v, 2) + alias_off, dt_of(v));
    end
    rd("R2", ent(2, 0), lo_of(2));
    rd("R2", ent(2, 2) + 32'(PAGE), dt_of(2));
    rd("R3", ent(1, 1), hi_of(1));
    rd("R3", ent(4, 2), dt_of(4));
    wr(ent(5, 3), 32'hFFFF_FFFE);
    rd("R3", ent(5, 3), 0);
    wr(ent(5, 3), 32'hFFFF_FFFF);
    rd("R3", ent(5, 3), 1);

    // R5 / R11: disabled, unmasked vector 0 only waits
    wr(ent(0, 3), 0);
    irq(8'h01);
    repeat (4) @(negedge clk);
    rd("R5", PEND, 32'h1);
    expect_msg(0, "R11");
    @(negedge clk); msix_en = 1'b1;
    repeat (4) @(negedge clk);
    rd("R11", PEND, 0);
    chk("R11", 64'(exp_q.size()), 0);

    // R5 / R7: masked vector 1 waits, unmask delivers
    irq(8'h02);
    repeat (4) @(negedge clk);
    rd("R5", PEND, 32'h2);
    rd("R4", PEND, 32'h2);
    expect_msg(1, "R7");
    wr(ent(1, 3), 0);
    repeat (4) @(negedge clk);
    rd("R7", PEND, 0);
    chk("R7", 64'(exp_q.size()), 0);

    // R6 timing and R8 content
    expect_msg(0, "R8");
    irq(8'h01);
    @(negedge clk);
    chk("R6", 64'(msg_valid), 1);
    repeat (3) @(negedge clk);
    rd("R6", PEND, 0);

    // R10 / R8: three together under a stalled port
    wr(ent(2, 3), 0);
    wr(ent(3, 3), 0);
    @(posedge clk); #2 msg_ready = 1'b0;
    expect_msg(1, "R10");
    expect_msg(2, "R10");
    expect_msg(3, "R10");
    irq(8'h0E);
    @(negedge clk);
    chk("R10", 64'(msg_valid), 1);
    repeat (3) @(negedge clk);
    chk("R8", 64'(msg_valid), 1);
    chk("R8", msg_addr, {hi_of(1), lo_of(1)});
    chk("R8", 64'(msg_data), 64'(dt_of(1)));
    @(posedge clk); #2 msg_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10", 64'(exp_q.size()), 0);

    // R9 and R4: writes to waiting bits ignored, vector 4 at bit 4
    irq(8'h10);
    repeat (3) @(negedge clk);
    rd("R4", PEND, 32'h10);
    wr(PEND, 0);
    rd("R9", PEND, 32'h10);
    wr(PEND, 32'hFFFF_FFFF);
    rd("R9", PEND, 32'h10);
    rd("R9", PEND + 4, 0);
    wr(ent(8, 0), 32'h1234_5678);
    rd("R9", ent(8, 0), 0);
    rd("R9", BASE + 32'h400, 0);
    repeat (4) @(negedge clk);
    chk("R9", 64'(exp_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule